// File: doc/BRIEF.md
# Configurable Digital Phase-Frequency Detector

This block compares two edge streams, a reference clock and a divided oscillator feedback clock, and reports their phase and frequency error as pulses. Both inputs arrive asynchronously. Each passes through a synchroniser, and its rising edge is detected in a fast system clock domain. Each detected edge sets a flag, one flag for each stream. When both flags are set, a small counter holds them together for a fixed minimum number of cycles and then clears both. This guaranteed coincident pulse keeps the transfer function linear near zero error, so there is no dead zone.

The flags drive two output forms:

- **Double-ended pair.** An active-low pair sits high at rest. The error appears as low pulses on one side of the pair.
- **Single-ended output.** A three-state output is modelled as a source strobe, a sink strobe and an output enable.

A polarity control swaps which side carries a given error sign. A disable control and a standby control each force both output forms to rest and clear the flags. The lock indication is the AND of the pair, gated by an enable input. It therefore stays low from reset until software enables it, so no false lock is shown at power-up.

Top module: `phase_freq_detector`

## Requirements
- R1: After synchronous reset, phi_r_n and phi_v_n are high, and pd_up, pd_dn and pd_oe are low.
- R2: With pol=0, when the oscillator edge arrives d cycles before the reference edge, phi_v_n is low for d+MIN_W cycles and phi_r_n is low for MIN_W cycles.
- R3: With pol=0, when the oscillator edge arrives d cycles after the reference edge, phi_r_n is low for d+MIN_W cycles and phi_v_n is low for MIN_W cycles.
- R4: With pol=1, the low-pulse counts of phi_r_n and phi_v_n are exchanged relative to pol=0 for the same input timing.
- R5: When both edges arrive in the same cycle, phi_r_n and phi_v_n go low together for exactly MIN_W cycles (default 2). The counter that times this never exceeds MIN_W-1.
- R6: The single-ended output is driven as follows:
  - With pol=0, pd_up follows the reference-side flag and pd_dn follows the oscillator-side flag. With pol=1 the two are exchanged, so an oscillator lead sources current.
  - pd_up and pd_dn are both high only while both flags are set.
  - pd_oe is high exactly when pd_up or pd_dn is high.
- R7: While det_off or standby is high, the pair stays high and pd_up, pd_dn and pd_oe stay low. Both flags are cleared, so no pulse remains after release.
- R8: lock equals ld_en AND phi_r_n AND phi_v_n. With ld_en low, lock is low, including from reset. Lock is never high while pd_oe is high.
- R9: An input held high produces exactly one detected edge. A rising edge reaches the flags 3 clock cycles after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than both compared streams |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference edge stream, asynchronous |
| vco_in | input | 1 | Divided oscillator edge stream, asynchronous |
| pol | input | 1 | Polarity select; 1 swaps the error sides |
| det_off | input | 1 | Detector disable; forces outputs to rest |
| standby | input | 1 | Standby; forces outputs to rest |
| ld_en | input | 1 | Lock indication enable |
| phi_r_n | output | 1 | Pair output, reference side, active low |
| phi_v_n | output | 1 | Pair output, oscillator side, active low |
| pd_up | output | 1 | Single-ended source strobe |
| pd_dn | output | 1 | Single-ended sink strobe |
| pd_oe | output | 1 | Single-ended drive enable; 0 means float |
| lock | output | 1 | Lock indication, AND of the pair when enabled |

## Verification
The assertions check several properties on every cycle:

- A detected edge never lasts two cycles.
- The coincidence counter stays in range, and a fresh coincidence always lasts beyond its first cycle.
- Disable or standby empties both flags by the next cycle.
- Concurrent source and sink strobes occur only while both flags are set.
- Lock never coincides with an active single-ended drive.

Some behaviour can only be shown by the bench's scenarios, which apply timed edge pairs and count output cycles. These are the exact pulse widths for lead, lag and equal timing under both polarities, and the swap of sides caused by the polarity bit. The same holds for the absence of a leftover pulse after standby, and for lock staying low from reset until enabled.

// File: rtl/pfd_pkg.sv
// Package: shared types for the phase-frequency detector.
// Assumes control inputs are already synchronous to clk.
package pfd_pkg;

    // Control word gathered from the block's control pins.
    typedef struct packed {
        logic pol;      // swap error sides
        logic off;      // detector disabled
        logic stby;     // standby
        logic ld_en;    // lock indication enabled
    } pfd_cfg_t;

    // Index of each compared stream in channel arrays.
    localparam int CH_REF = 0;
    localparam int CH_VCO = 1;
    localparam int N_CH   = 2;

endpackage

// File: rtl/pfd_sync_edge.sv
// Module: pfd_sync_edge
// Synchronises one asynchronous input through STAGES flops and emits a
// one-cycle strobe on each rising edge. Assumes STAGES >= 2.
module pfd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES:0] chain;

    // Shift the input through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-1:0], async_i};
    end

    // Rising edge: newest synchronised sample high, previous low.
    always_comb rise_o = chain[STAGES-1] & ~chain[STAGES];

    // R9
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/pfd_flags.sv
// Module: pfd_flags
// Holds the reference and oscillator error flags. Each is set by its own
// edge strobe; once both are set they are held MIN_W cycles, then cleared
// together. hold_i clears all state. Assumes MIN_W >= 1.
module pfd_flags #(
    parameter int MIN_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_i,
    input  logic rise_r_i,
    input  logic rise_v_i,
    output logic flag_r_o,
    output logic flag_v_o
);

    localparam int CNT_W = (MIN_W > 1) ? $clog2(MIN_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_W - 1);

    logic             both;
    logic             done;
    logic [CNT_W-1:0] cnt;

    // Coincidence detection and end of the minimum-width window.
    always_comb begin
        both = flag_r_o & flag_v_o;
        done = both && (cnt == LAST);
    end

    // Flag set on edge, clear at end of coincidence; counter times the window.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_i) begin
            flag_r_o <= 1'b0;
            flag_v_o <= 1'b0;
            cnt      <= '0;
        end else begin
            flag_r_o <= rise_r_i | (flag_r_o & ~done);
            flag_v_o <= rise_v_i | (flag_v_o & ~done);
            cnt      <= (both && !done) ? cnt + 1'b1 : '0;
        end
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R7
    hold_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (!flag_r_o && !flag_v_o));

    generate
        if (MIN_W > 1) begin : g_wide
            // R5
            coincide_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (both && cnt == '0 && !hold_i) |=> (flag_r_o && flag_v_o));
        end
    endgenerate

endmodule

// File: rtl/pfd_outmux.sv
// Module: pfd_outmux
// Maps the two error flags to the active-low pair and the single-ended
// strobes according to polarity, forces rest state when disabled or in
// standby, and forms the gated lock indication. Purely combinational.
module pfd_outmux
    import pfd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pfd_cfg_t cfg_i,
    input  logic     flag_r_i,
    input  logic     flag_v_i,
    output logic     phi_r_n_o,
    output logic     phi_v_n_o,
    output logic     up_o,
    output logic     dn_o,
    output logic     oe_o,
    output logic     lock_o
);

    logic rest;
    logic side_r;
    logic side_v;

    // Select which flag feeds each side, then apply forced rest state.
    always_comb begin
        rest   = cfg_i.off | cfg_i.stby;
        side_r = cfg_i.pol ? flag_v_i : flag_r_i;
        side_v = cfg_i.pol ? flag_r_i : flag_v_i;
        phi_r_n_o = rest | ~side_r;
        phi_v_n_o = rest | ~side_v;
        up_o      = ~rest & side_r;
        dn_o      = ~rest & side_v;
        oe_o      = up_o | dn_o;
        lock_o    = cfg_i.ld_en & phi_r_n_o & phi_v_n_o;
    end

    // R6
    dual_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && dn_o) |-> (flag_r_i && flag_v_i));

    // R8
    lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> !oe_o);

endmodule

// File: rtl/phase_freq_detector.sv
// Module: phase_freq_detector
// Top of the phase-frequency detector: two edge synchronisers, the error
// flag core and the output mapping. Assumes clk is several times faster
// than both compared streams and control pins are synchronous to clk.
module phase_freq_detector
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_W       = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    input  logic vco_in,
    input  logic pol,
    input  logic det_off,
    input  logic standby,
    input  logic ld_en,
    output logic phi_r_n,
    output logic phi_v_n,
    output logic pd_up,
    output logic pd_dn,
    output logic pd_oe,
    output logic lock
);

    logic [N_CH-1:0] raw_in;
    logic [N_CH-1:0] rise;
    logic            flag_r;
    logic            flag_v;
    pfd_cfg_t        cfg;

    // Gather inputs into channel order and the control word.
    always_comb begin
        raw_in[CH_REF] = ref_in;
        raw_in[CH_VCO] = vco_in;
        cfg.pol   = pol;
        cfg.off   = det_off;
        cfg.stby  = standby;
        cfg.ld_en = ld_en;
    end

    generate
        for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
            pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .async_i (raw_in[ch]),
                .rise_o  (rise[ch])
            );
        end
    endgenerate

    pfd_flags #(.MIN_W(MIN_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_i   (det_off | standby),
        .rise_r_i (rise[CH_REF]),
        .rise_v_i (rise[CH_VCO]),
        .flag_r_o (flag_r),
        .flag_v_o (flag_v)
    );

    pfd_outmux u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_i     (cfg),
        .flag_r_i  (flag_r),
        .flag_v_i  (flag_v),
        .phi_r_n_o (phi_r_n),
        .phi_v_n_o (phi_v_n),
        .up_o      (pd_up),
        .dn_o      (pd_dn),
        .oe_o      (pd_oe),
        .lock_o    (lock)
    );

endmodule

// File: tb/tb_phase_freq_detector.sv
// Bench: table of timed edge pairs with expected low/active cycle counts,
// then directed tests for reset, lock gating and standby mid-pulse.
module tb_phase_freq_detector;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;
    localparam int WIN = 16;
    localparam int WIDTH_HI = 4;

    // Fields: pol, off, stby, ld_en, d (vco edge minus ref edge, cycles),
    // exp phi_r_n low, phi_v_n low, lock low, pd_up, pd_dn, pd_oe counts.
    localparam int VEC [NV][11] = '{
        '{0,0,0,1, 0, 2,2, 2, 2,2, 2},
        '{0,0,0,1, 2, 4,2, 4, 4,2, 4},
        '{0,0,0,1,-3, 2,5, 5, 2,5, 5},
        '{1,0,0,1, 0, 2,2, 2, 2,2, 2},
        '{1,0,0,1, 2, 2,4, 4, 2,4, 4},
        '{1,0,0,1,-3, 5,2, 5, 5,2, 5},
        '{0,1,0,1, 2, 0,0, 0, 0,0, 0},
        '{1,0,1,1,-1, 0,0, 0, 0,0, 0},
        '{0,0,0,0, 1, 3,2,16, 3,2, 3},
        '{0,0,0,1, 1, 3,2, 3, 3,2, 3},
        '{1,0,0,1,-1, 3,2, 3, 3,2, 3},
        '{0,1,1,1, 0, 0,0, 0, 0,0, 0}
    };
    localparam string TAG [NV] = '{"R5","R3","R2","R4","R4","R4",
                                   "R7","R7","R8","R9","R6","R7"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, vco_in = 1'b0;
    logic pol = 1'b0, det_off = 1'b0, standby = 1'b0, ld_en = 1'b0;
    logic phi_r_n, phi_v_n, pd_up, pd_dn, pd_oe, lock;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phase_freq_detector dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .vco_in(vco_in),
        .pol(pol), .det_off(det_off), .standby(standby), .ld_en(ld_en),
        .phi_r_n(phi_r_n), .phi_v_n(phi_v_n), .pd_up(pd_up),
        .pd_dn(pd_dn), .pd_oe(pd_oe), .lock(lock)
    );

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input int got, input int exp);
        checks = checks + 1;
        if (got != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s got %0d exp %0d", req, what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        int ar, av;
        int c_r, c_v, c_ld, c_up, c_dn, c_oe;

        // R1 / R8: reset state with lock disabled.
        idle(3);
        rst_n = 1'b1;
        idle(2);
        check("R1", "phi_r_n after reset", int'(phi_r_n), 1);
        check("R1", "phi_v_n after reset", int'(phi_v_n), 1);
        check("R1", "pd_oe after reset", int'(pd_oe), 0);
        check("R1", "pd_up|pd_dn after reset", int'(pd_up | pd_dn), 0);
        check("R8", "lock low until enabled", int'(lock), 0);
        ld_en = 1'b1;
        @(negedge clk);
        check("R8", "lock high once enabled at rest", int'(lock), 1);

        // Table walk.
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            pol = VEC[v][0] != 0; det_off = VEC[v][1] != 0;
            standby = VEC[v][2] != 0; ld_en = VEC[v][3] != 0;
            idle(6);
            ar = (VEC[v][4] < 0) ? -VEC[v][4] : 0;
            av = ar + VEC[v][4];
            c_r = 0; c_v = 0; c_ld = 0; c_up = 0; c_dn = 0; c_oe = 0;
            for (int k = 0; k < WIN; k++) begin
                c_r  += int'(!phi_r_n);
                c_v  += int'(!phi_v_n);
                c_ld += int'(!lock);
                c_up += int'(pd_up);
                c_dn += int'(pd_dn);
                c_oe += int'(pd_oe);
                ref_in = (k >= ar) && (k < ar + WIDTH_HI);
                vco_in = (k >= av) && (k < av + WIDTH_HI);
                @(negedge clk);
            end
            ref_in = 1'b0; vco_in = 1'b0;
            check(TAG[v], $sformatf("vec %0d phi_r_n low", v), c_r,  VEC[v][5]);
            check(TAG[v], $sformatf("vec %0d phi_v_n low", v), c_v,  VEC[v][6]);
            check(TAG[v], $sformatf("vec %0d lock low", v),    c_ld, VEC[v][7]);
            check(TAG[v], $sformatf("vec %0d pd_up", v),       c_up, VEC[v][8]);
            check(TAG[v], $sformatf("vec %0d pd_dn", v),       c_dn, VEC[v][9]);
            check(TAG[v], $sformatf("vec %0d pd_oe", v),       c_oe, VEC[v][10]);
        end

        // R9: edge latency of three cycles, reference alone.
        @(negedge clk);
        pol = 1'b0; det_off = 1'b0; standby = 1'b0; ld_en = 1'b1;
        idle(6);
        ref_in = 1'b1;
        idle(2);
        check("R9", "phi_r_n still high 2 cycles after edge", int'(phi_r_n), 1);
        @(negedge clk);
        check("R9", "phi_r_n low 3 cycles after edge", int'(phi_r_n), 0);
        check("R6", "pd_up with lone reference flag", int'(pd_up), 1);
        check("R8", "lock low during error", int'(lock), 0);

        // R7: standby mid-pulse forces rest and leaves no stale pulse.
        standby = 1'b1;
        @(negedge clk);
        check("R7", "phi_r_n forced high in standby", int'(phi_r_n), 1);
        check("R7", "pd_oe floats in standby", int'(pd_oe), 0);
        standby = 1'b0;
        @(negedge clk);
        check("R7", "no pulse after standby release", int'(phi_r_n), 1);
        check("R7", "pd_oe stays low after release", int'(pd_oe), 0);
        ref_in = 1'b0;
        idle(4);

        // R1: reset during an error pulse returns the outputs to rest.
        vco_in = 1'b1;
        idle(4);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "phi_v_n high after mid-pulse reset", int'(phi_v_n), 1);
        vco_in = 1'b0;
        idle(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule